// File: doc/BRIEF.md
# Fractional PLL Output Rate Calculator

This block works out the output frequency of a fractional-N synthesizer from the reference frequency and the synthesizer's divider settings. A request carries the reference rate, an integer multiplier, a fractional numerator and denominator, a pre-divider code, a post-divider code and a mode flag that selects integer-only or fractional operation. The block latches the request, maps the two divider codes to their effective values, builds a 64-bit dividend and a 32-bit divisor, and runs a restoring divider that produces one quotient bit per cycle. The result is returned with a one-cycle strobe.

Fractional settings often cannot be recovered exactly by division. A small writable table of known settings is therefore searched first. An entry that matches the request's five divider fields returns its stored rate in place of the computed value. The controller is a five-state machine. IDLE moves to SCAN on an accepted start. SCAN goes to DONE on a table hit and to PREP on a miss. PREP goes to DONE when the divisor is zero and to DIVIDE otherwise. DIVIDE goes to DONE when the quotient is ready. DONE always returns to IDLE.

Top module: `pll_rate_calc`

## Requirements
- R1: In fractional mode (`int_mode`=0) with no table hit, `rate_out` = floor(ref × (mul × den + num) / (den × pre_eff × post_eff)), truncated to 32 bits.
- R2: In integer mode (`int_mode`=1) with no table hit, `rate_out` = floor(ref × mul / (pre_eff × post_eff)), and the numerator and denominator inputs have no effect on the result or on `rate_err`.
- R3: The effective pre-divider is 1 when `in_pre_code` is 0 and otherwise equals the code.
- R4: The effective post-divider is 2 when `in_post_code` is 0, 3 when it is 1, and otherwise equals the code.
- R5: A live table entry whose multiplier, numerator, denominator, pre code and post code all equal the request's fields is a hit, in either mode. On a hit the stored rate is returned with `rate_err`=0.
- R6: An entry written with `wr_live`=0 never hits. An entry that differs in any one of the five fields does not hit.
- R7: When several live entries hit, the entry with the highest slot index supplies the rate.
- R8: In fractional mode, a denominator of 0 with no table hit returns `rate_err`=1 and `rate_out`=0. Every other result has `rate_err`=0.
- R9: Each start accepted while `busy`=0 yields exactly one single-cycle `rate_valid` pulse. `busy` is high from the cycle after acceptance until the cycle after the pulse. A start raised while `busy`=1 is ignored.
- R10: After reset, `busy`, `rate_valid`, `rate_err` and `rate_out` are 0 and every table entry is not live.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe, accepted when idle |
| in_ref_rate | input | 32 | Reference frequency |
| in_mul_int | input | 9 | Integer multiplier |
| in_frac_num | input | 16 | Fractional numerator |
| in_frac_den | input | 16 | Fractional denominator |
| in_pre_code | input | 3 | Pre-divider code |
| in_post_code | input | 8 | Post-divider code |
| int_mode | input | 1 | 1 selects integer-only calculation |
| wr_en | input | 1 | Table write enable |
| wr_slot | input | 4 | Table slot to write |
| wr_live | input | 1 | Marks the written entry as live |
| wr_mul_int | input | 9 | Entry multiplier |
| wr_frac_num | input | 16 | Entry numerator |
| wr_frac_den | input | 16 | Entry denominator |
| wr_pre_code | input | 3 | Entry pre-divider code |
| wr_post_code | input | 8 | Entry post-divider code |
| wr_rate | input | 32 | Entry exact rate |
| busy | output | 1 | Request in progress |
| rate_valid | output | 1 | One-cycle result strobe |
| rate_err | output | 1 | Zero-divisor flag, valid with the strobe |
| rate_out | output | 32 | Result rate |

## Verification
The bench builds the block with its default parameters: 16 table slots, 32-bit reference and rate, and a 64-by-32 divider. With 16 slots the bench can place matching entries in slot 0 and slot 15 to show that the highest index wins. The 64-bit dividend lets realistic references near 24 MHz multiply into GHz-range rates, so the pre- and post-code mappings and a non-exact fractional quotient can be checked without overflow. A stimulus pattern changes every input while a request is in flight and then repeats reset with table entries present, which shows that latched fields and reset behave as required.

// File: rtl/pll_rate_pkg.sv
package pll_rate_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SCAN,
        ST_PREP,
        ST_DIVIDE,
        ST_DONE
    } calc_state_e;

endpackage

// File: rtl/prt_table.sv
module prt_table #(
    parameter int DEPTH  = 16,
    parameter int MUL_W  = 9,
    parameter int FRAC_W = 16,
    parameter int PRE_W  = 3,
    parameter int POST_W = 8,
    parameter int RATE_W = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_slot,
    input  logic              wr_live,
    input  logic [MUL_W-1:0]  wr_mul,
    input  logic [FRAC_W-1:0] wr_num,
    input  logic [FRAC_W-1:0] wr_den,
    input  logic [PRE_W-1:0]  wr_pre,
    input  logic [POST_W-1:0] wr_post,
    input  logic [RATE_W-1:0] wr_rate,
    input  logic [MUL_W-1:0]  q_mul,
    input  logic [FRAC_W-1:0] q_num,
    input  logic [FRAC_W-1:0] q_den,
    input  logic [PRE_W-1:0]  q_pre,
    input  logic [POST_W-1:0] q_post,
    output logic              hit,
    output logic [RATE_W-1:0] hit_rate
);

    logic [DEPTH-1:0]  live_q;
    logic [MUL_W-1:0]  mul_q  [DEPTH];
    logic [FRAC_W-1:0] num_q  [DEPTH];
    logic [FRAC_W-1:0] den_q  [DEPTH];
    logic [PRE_W-1:0]  pre_q  [DEPTH];
    logic [POST_W-1:0] post_q [DEPTH];
    logic [RATE_W-1:0] rate_q [DEPTH];
    logic [DEPTH-1:0]  match;

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                live_q[g] <= 1'b0;
            end else if (wr_en && (wr_slot == IDX_W'(g))) begin
                live_q[g] <= wr_live;
            end
        end

        always_ff @(posedge clk) begin
            if (wr_en && (wr_slot == IDX_W'(g))) begin
                mul_q[g]  <= wr_mul;
                num_q[g]  <= wr_num;
                den_q[g]  <= wr_den;
                pre_q[g]  <= wr_pre;
                post_q[g] <= wr_post;
                rate_q[g] <= wr_rate;
            end
        end

        assign match[g] = live_q[g]
                        && (mul_q[g]  == q_mul)
                        && (num_q[g]  == q_num)
                        && (den_q[g]  == q_den)
                        && (pre_q[g]  == q_pre)
                        && (post_q[g] == q_post);
    end

    // Ascending scan: the last matching slot overrides earlier ones.
    always_comb begin
        hit      = 1'b0;
        hit_rate = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (match[i]) begin
                hit      = 1'b1;
                hit_rate = rate_q[i];
            end
        end
    end

endmodule

// File: rtl/prt_decode.sv
module prt_decode #(
    parameter int REF_W  = 32,
    parameter int MUL_W  = 9,
    parameter int FRAC_W = 16,
    parameter int PRE_W  = 3,
    parameter int POST_W = 8,
    parameter int DVD_W  = 64,
    parameter int DVS_W  = 32
) (
    input  logic [REF_W-1:0]  ref_rate,
    input  logic [MUL_W-1:0]  mul_int,
    input  logic [FRAC_W-1:0] frac_num,
    input  logic [FRAC_W-1:0] frac_den,
    input  logic [PRE_W-1:0]  pre_code,
    input  logic [POST_W-1:0] post_code,
    input  logic              int_mode,
    output logic [DVD_W-1:0]  dividend,
    output logic [DVS_W-1:0]  divisor,
    output logic              div_zero
);

    logic [PRE_W-1:0]  pre_eff;
    logic [POST_W-1:0] post_eff;
    logic [DVD_W-1:0]  mul_sum;
    logic [DVS_W-1:0]  den_path;

    always_comb begin
        pre_eff = (pre_code == '0) ? PRE_W'(1) : pre_code;
        unique case (post_code)
            POST_W'(0): post_eff = POST_W'(2);
            POST_W'(1): post_eff = POST_W'(3);
            default:    post_eff = post_code;
        endcase
    end

    always_comb begin
        den_path = DVS_W'(pre_eff) * DVS_W'(post_eff);
        mul_sum  = DVD_W'(mul_int) * DVD_W'(frac_den) + DVD_W'(frac_num);
        if (int_mode) begin
            dividend = DVD_W'(ref_rate) * DVD_W'(mul_int);
            divisor  = den_path;
        end else begin
            dividend = DVD_W'(ref_rate) * mul_sum;
            divisor  = DVS_W'(frac_den) * den_path;
        end
        div_zero = (divisor == '0);
    end

endmodule

// File: rtl/prt_divider.sv
module prt_divider #(
    parameter int DVD_W = 64,
    parameter int DVS_W = 32,
    parameter int Q_W   = 32,
    localparam int CW   = $clog2(DVD_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [DVD_W-1:0] dividend,
    input  logic [DVS_W-1:0] divisor,
    output logic             done,
    output logic [Q_W-1:0]   quotient
);

    logic [DVD_W-1:0] quo_q;
    logic [DVS_W-1:0] rem_q;
    logic [DVS_W-1:0] dsr_q;
    logic [CW-1:0]    cnt_q;
    logic             run_q;
    logic [DVS_W:0]   shifted;
    logic [DVS_W:0]   trial;

    always_comb begin
        shifted = {rem_q, quo_q[DVD_W-1]};
        trial   = shifted - {1'b0, dsr_q};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            quo_q <= '0;
            rem_q <= '0;
            dsr_q <= '0;
            cnt_q <= '0;
            run_q <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (go && !run_q) begin
                quo_q <= dividend;
                rem_q <= '0;
                dsr_q <= divisor;
                cnt_q <= CW'(DVD_W);
                run_q <= 1'b1;
            end else if (run_q) begin
                if (!trial[DVS_W]) begin
                    rem_q <= trial[DVS_W-1:0];
                    quo_q <= {quo_q[DVD_W-2:0], 1'b1};
                end else begin
                    rem_q <= shifted[DVS_W-1:0];
                    quo_q <= {quo_q[DVD_W-2:0], 1'b0};
                end
                cnt_q <= cnt_q - CW'(1);
                if (cnt_q == CW'(1)) begin
                    run_q <= 1'b0;
                    done  <= 1'b1;
                end
            end
        end
    end

    assign quotient = quo_q[Q_W-1:0];

endmodule

// File: rtl/pll_rate_calc.sv
module pll_rate_calc
    import pll_rate_pkg::*;
#(
    parameter int REF_W   = 32,
    parameter int MUL_W   = 9,
    parameter int FRAC_W  = 16,
    parameter int PRE_W   = 3,
    parameter int POST_W  = 8,
    parameter int RATE_W  = 32,
    parameter int DEPTH   = 16,
    parameter int DVD_W   = 64,
    parameter int DVS_W   = 32,
    localparam int IDX_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [REF_W-1:0]  in_ref_rate,
    input  logic [MUL_W-1:0]  in_mul_int,
    input  logic [FRAC_W-1:0] in_frac_num,
    input  logic [FRAC_W-1:0] in_frac_den,
    input  logic [PRE_W-1:0]  in_pre_code,
    input  logic [POST_W-1:0] in_post_code,
    input  logic              int_mode,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_slot,
    input  logic              wr_live,
    input  logic [MUL_W-1:0]  wr_mul_int,
    input  logic [FRAC_W-1:0] wr_frac_num,
    input  logic [FRAC_W-1:0] wr_frac_den,
    input  logic [PRE_W-1:0]  wr_pre_code,
    input  logic [POST_W-1:0] wr_post_code,
    input  logic [RATE_W-1:0] wr_rate,
    output logic              busy,
    output logic              rate_valid,
    output logic              rate_err,
    output logic [RATE_W-1:0] rate_out
);

    calc_state_e state_q, state_d;

    logic [REF_W-1:0]  ref_q;
    logic [MUL_W-1:0]  mul_q;
    logic [FRAC_W-1:0] num_q;
    logic [FRAC_W-1:0] den_q;
    logic [PRE_W-1:0]  pre_q;
    logic [POST_W-1:0] post_q;
    logic              imode_q;

    logic              tbl_hit;
    logic [RATE_W-1:0] tbl_rate;
    logic [DVD_W-1:0]  dividend;
    logic [DVS_W-1:0]  divisor;
    logic              div_zero;
    logic              div_go;
    logic              div_done;
    logic [RATE_W-1:0] div_quot;

    prt_table #(
        .DEPTH(DEPTH), .MUL_W(MUL_W), .FRAC_W(FRAC_W),
        .PRE_W(PRE_W), .POST_W(POST_W), .RATE_W(RATE_W)
    ) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_slot  (wr_slot),
        .wr_live  (wr_live),
        .wr_mul   (wr_mul_int),
        .wr_num   (wr_frac_num),
        .wr_den   (wr_frac_den),
        .wr_pre   (wr_pre_code),
        .wr_post  (wr_post_code),
        .wr_rate  (wr_rate),
        .q_mul    (mul_q),
        .q_num    (num_q),
        .q_den    (den_q),
        .q_pre    (pre_q),
        .q_post   (post_q),
        .hit      (tbl_hit),
        .hit_rate (tbl_rate)
    );

    prt_decode #(
        .REF_W(REF_W), .MUL_W(MUL_W), .FRAC_W(FRAC_W),
        .PRE_W(PRE_W), .POST_W(POST_W), .DVD_W(DVD_W), .DVS_W(DVS_W)
    ) u_decode (
        .ref_rate  (ref_q),
        .mul_int   (mul_q),
        .frac_num  (num_q),
        .frac_den  (den_q),
        .pre_code  (pre_q),
        .post_code (post_q),
        .int_mode  (imode_q),
        .dividend  (dividend),
        .divisor   (divisor),
        .div_zero  (div_zero)
    );

    prt_divider #(
        .DVD_W(DVD_W), .DVS_W(DVS_W), .Q_W(RATE_W)
    ) u_divider (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (div_go),
        .dividend (dividend),
        .divisor  (divisor),
        .done     (div_done),
        .quotient (div_quot)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_SCAN;
            ST_SCAN:   state_d = tbl_hit  ? ST_DONE : ST_PREP;
            ST_PREP:   state_d = div_zero ? ST_DONE : ST_DIVIDE;
            ST_DIVIDE: if (div_done) state_d = ST_DONE;
            ST_DONE:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Outputs decoded from state
    always_comb begin
        busy       = (state_q != ST_IDLE);
        rate_valid = (state_q == ST_DONE);
        div_go     = (state_q == ST_PREP) && !div_zero;
    end

    // Request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_q   <= '0;
            mul_q   <= '0;
            num_q   <= '0;
            den_q   <= '0;
            pre_q   <= '0;
            post_q  <= '0;
            imode_q <= 1'b0;
        end else if ((state_q == ST_IDLE) && start) begin
            ref_q   <= in_ref_rate;
            mul_q   <= in_mul_int;
            num_q   <= in_frac_num;
            den_q   <= in_frac_den;
            pre_q   <= in_pre_code;
            post_q  <= in_post_code;
            imode_q <= int_mode;
        end
    end

    // Result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rate_out <= '0;
            rate_err <= 1'b0;
        end else begin
            unique case (state_q)
                ST_SCAN: if (tbl_hit) begin
                    rate_out <= tbl_rate;
                    rate_err <= 1'b0;
                end
                ST_PREP: if (div_zero) begin
                    rate_out <= '0;
                    rate_err <= 1'b1;
                end
                ST_DIVIDE: if (div_done) begin
                    rate_out <= div_quot;
                    rate_err <= 1'b0;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/pll_rate_calc_checker.sv
module pll_rate_calc_checker #(
    parameter int RATE_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              rate_valid,
    input logic              rate_err,
    input logic [RATE_W-1:0] rate_out
);

    a_r9_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        rate_valid |=> !rate_valid);

    a_r9_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    a_r9_valid_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
        rate_valid |=> !busy);

    a_r9_valid_within_busy: assert property (@(posedge clk) disable iff (!rst_n)
        rate_valid |-> busy);

    a_r8_err_zero_rate: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_valid && rate_err) |-> (rate_out == '0));

    a_r9_result_stable_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(rate_out));

endmodule

bind pll_rate_calc pll_rate_calc_checker #(.RATE_W(RATE_W)) i_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .busy       (busy),
    .rate_valid (rate_valid),
    .rate_err   (rate_err),
    .rate_out   (rate_out)
);

// File: tb/test_pll_rate_calc.sv
module test_pll_rate_calc;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [31:0] rf;
        logic [8:0]  mi;
        logic [15:0] fn;
        logic [15:0] fd;
        logic [2:0]  pc;
        logic [7:0]  oc;
        logic        im;
    } req_t;

    typedef struct {
        logic [31:0] r;
        logic        e;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    req_t        cur = '0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_slot = '0;
    logic        wr_live = 1'b0;
    req_t        wf = '0;
    logic [31:0] wr_rate = '0;
    logic        busy, rate_valid, rate_err;
    logic [31:0] rate_out;

    int   total = 0;
    int   fails = 0;
    exp_t sb[$];

    bit          sh_live [16];
    req_t        sh_f    [16];
    logic [31:0] sh_r    [16];

    always #(CLK_PERIOD/2) clk = ~clk;

    pll_rate_calc i_pll_rate_calc (
        .clk(clk), .rst_n(rst_n), .start(start),
        .in_ref_rate(cur.rf), .in_mul_int(cur.mi), .in_frac_num(cur.fn),
        .in_frac_den(cur.fd), .in_pre_code(cur.pc), .in_post_code(cur.oc),
        .int_mode(cur.im),
        .wr_en(wr_en), .wr_slot(wr_slot), .wr_live(wr_live),
        .wr_mul_int(wf.mi), .wr_frac_num(wf.fn), .wr_frac_den(wf.fd),
        .wr_pre_code(wf.pc), .wr_post_code(wf.oc), .wr_rate(wr_rate),
        .busy(busy), .rate_valid(rate_valid), .rate_err(rate_err),
        .rate_out(rate_out)
    );

    function automatic bit fields_eq(req_t a, req_t b);
        return a.mi == b.mi && a.fn == b.fn && a.fd == b.fd
            && a.pc == b.pc && a.oc == b.oc;
    endfunction

    // Expected result from the requirements
    function automatic exp_t model(req_t f, string tag);
        exp_t x;
        longint unsigned pre, post, num, den;
        x.tag = tag;
        for (int i = 15; i >= 0; i--) begin
            if (sh_live[i] && fields_eq(sh_f[i], f)) begin
                x.r = sh_r[i]; x.e = 1'b0;
                return x;
            end
        end
        pre  = (f.pc == 0) ? 1 : longint'(f.pc);
        post = (f.oc == 0) ? 2 : (f.oc == 1) ? 3 : longint'(f.oc);
        if (f.im) begin
            num = longint'(f.rf) * longint'(f.mi);
            den = pre * post;
        end else begin
            num = longint'(f.rf) * (longint'(f.mi) * longint'(f.fd) + longint'(f.fn));
            den = longint'(f.fd) * pre * post;
        end
        if (den == 0) begin
            x.r = '0; x.e = 1'b1;
        end else begin
            x.r = 32'(num / den); x.e = 1'b0;
        end
        return x;
    endfunction

    function automatic req_t mk(logic [31:0] rf, logic [8:0] mi, logic [15:0] fn,
                                logic [15:0] fd, logic [2:0] pc, logic [7:0] oc,
                                logic im);
        req_t f;
        f.rf = rf; f.mi = mi; f.fn = fn; f.fd = fd; f.pc = pc; f.oc = oc; f.im = im;
        return f;
    endfunction

    task automatic check(bit ok, string tag, string what, longint act, longint exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard on each result strobe
    always @(negedge clk) begin
        if (rst_n && rate_valid) begin
            if (sb.size() == 0) begin
                check(1'b0, "R9", "unexpected strobe", 1, 0);
            end else begin
                exp_t x;
                x = sb.pop_front();
                check(rate_out == x.r && rate_err == x.e, x.tag, "rate",
                      longint'({rate_err, rate_out}), longint'({x.e, x.r}));
            end
        end
    end

    task automatic tbl_write(int slot, bit live, req_t f, logic [31:0] r);
        @(negedge clk);
        wr_en = 1'b1; wr_slot = 4'(slot); wr_live = live; wf = f; wr_rate = r;
        @(negedge clk);
        wr_en = 1'b0;
        sh_live[slot] = live; sh_f[slot] = f; sh_r[slot] = r;
    endtask

    task automatic wait_drain();
        while (sb.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic run(req_t f, string tag);
        sb.push_back(model(f, tag));
        @(negedge clk);
        cur = f; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_drain();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < 16; i++) sh_live[i] = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog", "timeout", 0, 1);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        req_t a, b;
        for (int i = 0; i < 16; i++) sh_live[i] = 1'b0;
        repeat (3) @(negedge clk);
        // R10: outputs idle right after reset
        check(!busy && !rate_valid && !rate_err && rate_out == 0, "R10", "reset outputs",
              longint'({busy, rate_valid, rate_err}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 and R3: fractional, pre code 0
        run(mk(24000000, 162, 50, 100, 0, 6, 0), "R1_R3");
        // R1: non-exact quotient
        run(mk(25000000, 100, 1, 3, 1, 7, 0), "R1");
        // R2: integer, numerator garbage and zero denominator ignored
        run(mk(24000000, 141, 777, 0, 1, 2, 1), "R2");
        run(mk(24000000, 141, 5, 9, 1, 2, 1), "R2");
        // R4: post code mapping
        run(mk(24000000, 150, 0, 0, 1, 0, 1), "R4");
        run(mk(24000000, 150, 0, 0, 1, 1, 1), "R4");
        run(mk(24000000, 150, 0, 0, 1, 12, 1), "R4");
        // R3: pre code 0 versus explicit codes
        run(mk(24000000, 100, 0, 0, 0, 4, 1), "R3");
        run(mk(24000000, 100, 0, 0, 2, 4, 1), "R3");
        // R8: zero denominator in fractional mode
        run(mk(24000000, 100, 3, 0, 1, 4, 0), "R8");

        // R5: exact-match entry returns its stored rate, in both modes
        tbl_write(3, 1'b1, mk(0, 162, 50, 100, 0, 6, 0), 32'd650000001);
        run(mk(24000000, 162, 50, 100, 0, 6, 0), "R5");
        run(mk(24000000, 162, 50, 100, 0, 6, 1), "R5");
        // R6: one field differs, and a non-live entry
        run(mk(24000000, 162, 51, 100, 0, 6, 0), "R6");
        tbl_write(4, 1'b0, mk(0, 120, 0, 1, 1, 6, 0), 32'd777);
        run(mk(24000000, 120, 0, 1, 1, 6, 0), "R6");
        // R7: two live matches, highest slot wins
        tbl_write(0, 1'b1, mk(0, 90, 7, 11, 1, 5, 0), 32'd1111);
        tbl_write(15, 1'b1, mk(0, 90, 7, 11, 1, 5, 0), 32'd2222);
        run(mk(24000000, 90, 7, 11, 1, 5, 0), "R7");

        // R9: start while busy ignored, inputs changing mid-request
        a = mk(24000000, 140, 0, 1, 0, 6, 0);
        b = mk(30000000, 200, 0, 0, 1, 12, 1);
        sb.push_back(model(a, "R9"));
        @(negedge clk);
        cur = a; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        cur = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_drain();
        repeat (80) @(negedge clk);
        check(!busy, "R9", "busy after ignored start", longint'(busy), 0);

        // R10: table cleared by reset
        do_reset();
        run(mk(24000000, 162, 50, 100, 0, 6, 0), "R10");

        repeat (5) @(negedge clk);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule